// File: doc/BRIEF.md
# Dual-Container Instruction Issue Sequencer

This block sits between instruction fetch and a single execution slot. Each accepted 32-bit fetch word holds either one long instruction or two 15-bit short instructions, one in each container. The block turns the word into one or two issue beats, each with a payload, a container tag and a valid strobe. The top two bits of the word select one of four cases: a long instruction, a left-then-right pair, a right-then-left pair, or a parallel pair.

Execution feeds back two results while the first beat of a pair is on the outputs. One is a branch-taken flag, which cancels the second beat of an ordered pair. The other is a condition result, which gates the partner of a parallel-pair instruction that has to lead. Decode supplies a per-container "must lead" flag alongside the word. The block holds off the next word while a second beat is pending. It also keeps one wrapping event counter per container tag.

Top module: `dual_issue_seq`

## Requirements
- R1: A word with bits 31:30 = 2'b11 issues exactly once, one cycle after acceptance, with tag 0 (long) and payload = bits 29:0. No second beat follows.
- R2: Bits 31:30 = 2'b01 first issue the left container (bits 29:15, zero-extended to 30 bits) with tag 1 (left), one cycle after acceptance. The next cycle issues the right container (bits 14:0) with tag 2 (right).
- R3: Bits 31:30 = 2'b10 first issue the right container with tag 2. The next cycle issues the left container with tag 1.
- R4: In an ordered pair (2'b01 or 2'b10), a high branch_taken_i during the cycle the first beat is presented cancels the second beat: issue_valid_o is low in the next cycle.
- R5: Bits 31:30 = 2'b00 with neither must-lead flag set issue the left container with tag 3 (left-parallel), then the right container with tag 4 (right-parallel). Both beats always issue.
- R6: In a 2'b00 word whose left must-lead flag is set (whatever the right flag), the left container issues first with tag 1. The right container then issues with tag 2 only if exec_cond_i is high during the first beat.
- R7: In a 2'b00 word with only the right must-lead flag set, the right container issues first with tag 2. The left container then issues with tag 1 only if exec_cond_i is high during the first beat.
- R8: The must-lead flags and exec_cond_i have no effect on words other than 2'b00. branch_taken_i has no effect on 2'b00 words.
- R9: word_ready_o is low in the cycle after a pair word is accepted and high again the cycle after. It stays high after a long word.
- R10: Each issue beat adds one to the counter of its tag, visible one cycle after the beat. The other counters hold.
- R11: Synchronous active-high reset removes any pending beat, drops issue_valid_o, raises word_ready_o and zeroes all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| word_i | input | 32 | Fetched instruction word |
| word_valid_i | input | 1 | Fetch word is offered |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| must_lead_left_i | input | 1 | Left container instruction must lead a parallel pair |
| must_lead_right_i | input | 1 | Right container instruction must lead a parallel pair |
| branch_taken_i | input | 1 | First beat changed the program counter |
| exec_cond_i | input | 1 | Execute condition produced by the first beat |
| issue_valid_o | output | 1 | Issue beat strobe |
| issue_tag_o | output | 3 | Container tag: 0 long, 1 left, 2 right, 3 left-parallel, 4 right-parallel |
| issue_payload_o | output | 30 | Instruction payload, short ones zero-extended |
| cnt_long_o | output | 16 | Long-tag beats issued |
| cnt_left_o | output | 16 | Left-tag beats issued |
| cnt_right_o | output | 16 | Right-tag beats issued |
| cnt_lpar_o | output | 16 | Left-parallel beats issued |
| cnt_rpar_o | output | 16 | Right-parallel beats issued |

## Verification
Each directed word puts a different pattern in each container: all ones in one, a distinct value or zero in the other. A swapped order or a missing zero-extension then shows up as a wrong payload, not just a wrong tag. The two ordered encodings are each run with the branch flag high and low, which separates cancellation from ordering. Parallel words are run with every must-lead combination against both condition values, which shows the left-first priority and the gating. The stray flags are set on words where they should do nothing. Random words with random flags then drive the counters through all five tags and check them against a running model.

// File: rtl/dis_pkg.sv
package dis_pkg;
    localparam int WORD_W    = 32;
    localparam int SHORT_W   = 15;
    localparam int PAYLOAD_W = WORD_W - 2;
    localparam int TAG_W     = 3;
    localparam int NUM_TAGS  = 5;

    localparam logic [1:0] MODE_PAR  = 2'b00;
    localparam logic [1:0] MODE_LR   = 2'b01;
    localparam logic [1:0] MODE_RL   = 2'b10;
    localparam logic [1:0] MODE_LONG = 2'b11;

    typedef enum logic [TAG_W-1:0] {
        TAG_LONG  = 3'd0,
        TAG_LEFT  = 3'd1,
        TAG_RIGHT = 3'd2,
        TAG_LPAR  = 3'd3,
        TAG_RPAR  = 3'd4
    } tag_e;

    typedef enum logic [1:0] {
        GATE_NONE   = 2'd0,
        GATE_BRANCH = 2'd1,
        GATE_COND   = 2'd2
    } gate_e;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] first_payload;
        tag_e                 first_tag;
        logic [PAYLOAD_W-1:0] second_payload;
        tag_e                 second_tag;
        logic                 has_second;
        gate_e                gate;
    } plan_t;

    typedef struct packed {
        logic                 pend;
        logic [PAYLOAD_W-1:0] hold_payload;
        tag_e                 hold_tag;
        gate_e                hold_gate;
        logic                 out_valid;
        logic [PAYLOAD_W-1:0] out_payload;
        tag_e                 out_tag;
    } seq_state_t;
endpackage

// File: rtl/dis_classify.sv
module dis_classify
    import dis_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              lead_left_i,
    input  logic              lead_right_i,
    output plan_t             plan_o
);
    localparam int PAD_W = PAYLOAD_W - SHORT_W;

    logic [1:0]           mode;
    logic [PAYLOAD_W-1:0] left_ext;
    logic [PAYLOAD_W-1:0] right_ext;

    assign mode      = word_i[WORD_W-1 -: 2];
    assign left_ext  = {{PAD_W{1'b0}}, word_i[2*SHORT_W-1:SHORT_W]};
    assign right_ext = {{PAD_W{1'b0}}, word_i[SHORT_W-1:0]};

    always_comb begin
        plan_o = '0;
        unique case (mode)
            MODE_LONG: begin
                plan_o.first_payload = word_i[PAYLOAD_W-1:0];
                plan_o.first_tag     = TAG_LONG;
                plan_o.has_second    = 1'b0;
                plan_o.gate          = GATE_NONE;
            end
            MODE_LR: begin
                plan_o.first_payload  = left_ext;
                plan_o.first_tag      = TAG_LEFT;
                plan_o.second_payload = right_ext;
                plan_o.second_tag     = TAG_RIGHT;
                plan_o.has_second     = 1'b1;
                plan_o.gate           = GATE_BRANCH;
            end
            MODE_RL: begin
                plan_o.first_payload  = right_ext;
                plan_o.first_tag      = TAG_RIGHT;
                plan_o.second_payload = left_ext;
                plan_o.second_tag     = TAG_LEFT;
                plan_o.has_second     = 1'b1;
                plan_o.gate           = GATE_BRANCH;
            end
            default: begin
                plan_o.has_second = 1'b1;
                if (lead_left_i) begin
                    plan_o.first_payload  = left_ext;
                    plan_o.first_tag      = TAG_LEFT;
                    plan_o.second_payload = right_ext;
                    plan_o.second_tag     = TAG_RIGHT;
                    plan_o.gate           = GATE_COND;
                end else if (lead_right_i) begin
                    plan_o.first_payload  = right_ext;
                    plan_o.first_tag      = TAG_RIGHT;
                    plan_o.second_payload = left_ext;
                    plan_o.second_tag     = TAG_LEFT;
                    plan_o.gate           = GATE_COND;
                end else begin
                    plan_o.first_payload  = left_ext;
                    plan_o.first_tag      = TAG_LPAR;
                    plan_o.second_payload = right_ext;
                    plan_o.second_tag     = TAG_RPAR;
                    plan_o.gate           = GATE_NONE;
                end
            end
        endcase
    end
endmodule

// File: rtl/dis_sequencer.sv
module dis_sequencer
    import dis_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 word_valid_i,
    output logic                 word_ready_o,
    input  plan_t                plan_i,
    input  logic                 branch_taken_i,
    input  logic                 exec_cond_i,
    output logic                 issue_valid_o,
    output tag_e                 issue_tag_o,
    output logic [PAYLOAD_W-1:0] issue_payload_o
);
    seq_state_t q, d;
    logic       go_second;

    always_comb begin
        unique case (q.hold_gate)
            GATE_BRANCH: go_second = !branch_taken_i;
            GATE_COND:   go_second = exec_cond_i;
            default:     go_second = 1'b1;
        endcase
    end

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        if (q.pend) begin
            d.pend = 1'b0;
            if (go_second) begin
                d.out_valid   = 1'b1;
                d.out_payload = q.hold_payload;
                d.out_tag     = q.hold_tag;
            end
        end else if (word_valid_i) begin
            d.out_valid   = 1'b1;
            d.out_payload = plan_i.first_payload;
            d.out_tag     = plan_i.first_tag;
            if (plan_i.has_second) begin
                d.pend         = 1'b1;
                d.hold_payload = plan_i.second_payload;
                d.hold_tag     = plan_i.second_tag;
                d.hold_gate    = plan_i.gate;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign word_ready_o    = !q.pend;
    assign issue_valid_o   = q.out_valid;
    assign issue_tag_o     = q.out_tag;
    assign issue_payload_o = q.out_payload;

    // R4: a taken branch during the first beat suppresses the second
    a_r4_branch_cancel: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.pend && q.hold_gate == GATE_BRANCH && branch_taken_i) |=> !issue_valid_o);

    // R5: a plain parallel pair always delivers its second beat
    a_r5_par_complete: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.pend && q.hold_gate == GATE_NONE) |=> (issue_valid_o && issue_tag_o == TAG_RPAR));

    // R6 / R7: a false condition suppresses the partner of a leading instruction
    a_r6_cond_gate: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.pend && q.hold_gate == GATE_COND && !exec_cond_i) |=> !issue_valid_o);
endmodule

// File: rtl/dis_tag_counters.sv
module dis_tag_counters
    import dis_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk_i,
    input  logic                              rst_i,
    input  logic                              issue_valid_i,
    input  logic [TAG_W-1:0]                  issue_tag_i,
    output logic [NUM_TAGS-1:0][CNT_W-1:0]    cnt_o
);
    logic [NUM_TAGS-1:0][CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (issue_valid_i && issue_tag_i == TAG_W'(i)) begin
                cnt_d[i] = cnt_q[i] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cnt_chk
        // R10: a beat of this tag steps its counter by one
        a_r10_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
            (issue_valid_i && issue_tag_i == TAG_W'(g)) |=> cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1));
        // R10: any other cycle leaves this counter alone
        a_r10_count_hold: assert property (@(posedge clk_i) disable iff (rst_i)
            !(issue_valid_i && issue_tag_i == TAG_W'(g)) |=> $stable(cnt_q[g]));
    end
endmodule

// File: rtl/dual_issue_seq.sv
module dual_issue_seq
    import dis_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [WORD_W-1:0]    word_i,
    input  logic                 word_valid_i,
    output logic                 word_ready_o,
    input  logic                 must_lead_left_i,
    input  logic                 must_lead_right_i,
    input  logic                 branch_taken_i,
    input  logic                 exec_cond_i,
    output logic                 issue_valid_o,
    output logic [TAG_W-1:0]     issue_tag_o,
    output logic [PAYLOAD_W-1:0] issue_payload_o,
    output logic [CNT_W-1:0]     cnt_long_o,
    output logic [CNT_W-1:0]     cnt_left_o,
    output logic [CNT_W-1:0]     cnt_right_o,
    output logic [CNT_W-1:0]     cnt_lpar_o,
    output logic [CNT_W-1:0]     cnt_rpar_o
);
    plan_t                          plan;
    tag_e                           tag;
    logic [NUM_TAGS-1:0][CNT_W-1:0] cnt_all;
    logic                           accept;

    dis_classify u_classify (
        .word_i       (word_i),
        .lead_left_i  (must_lead_left_i),
        .lead_right_i (must_lead_right_i),
        .plan_o       (plan)
    );

    dis_sequencer u_seq (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .word_valid_i    (word_valid_i),
        .word_ready_o    (word_ready_o),
        .plan_i          (plan),
        .branch_taken_i  (branch_taken_i),
        .exec_cond_i     (exec_cond_i),
        .issue_valid_o   (issue_valid_o),
        .issue_tag_o     (tag),
        .issue_payload_o (issue_payload_o)
    );

    assign issue_tag_o = tag;

    dis_tag_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .issue_valid_i (issue_valid_o),
        .issue_tag_i   (issue_tag_o),
        .cnt_o         (cnt_all)
    );

    assign cnt_long_o  = cnt_all[TAG_LONG];
    assign cnt_left_o  = cnt_all[TAG_LEFT];
    assign cnt_right_o = cnt_all[TAG_RIGHT];
    assign cnt_lpar_o  = cnt_all[TAG_LPAR];
    assign cnt_rpar_o  = cnt_all[TAG_RPAR];

    assign accept = word_valid_i && word_ready_o;

    // R1: a long word appears once, whole, one cycle after acceptance
    a_r1_long_issue: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && word_i[WORD_W-1 -: 2] == MODE_LONG) |=>
        (issue_valid_o && issue_tag_o == 3'd0 && issue_payload_o == $past(word_i[PAYLOAD_W-1:0])));

    // R2: an ordered left-first word leads with the zero-extended left container
    a_r2_left_first: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && word_i[WORD_W-1 -: 2] == MODE_LR) |=>
        (issue_valid_o && issue_tag_o == 3'd1 &&
         issue_payload_o == {{(PAYLOAD_W-SHORT_W){1'b0}}, $past(word_i[2*SHORT_W-1:SHORT_W])}));

    // R9: accepting a pair closes the input for the following cycle
    a_r9_ready_drop: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && word_i[WORD_W-1 -: 2] != MODE_LONG) |=> !word_ready_o);
endmodule

// File: tb/dual_issue_seq_tb_top.sv
module dual_issue_seq_tb_top;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] word;
    logic        wvalid, wready;
    logic        mll, mlr, br, cond;
    logic        ivalid;
    logic [2:0]  itag;
    logic [29:0] ipay;
    logic [CW-1:0] c_long, c_left, c_right, c_lpar, c_rpar;

    int checks = 0;
    int fails  = 0;
    int model_cnt[5];

    always #4 clk = ~clk;

    dual_issue_seq #(.CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_i(rst), .word_i(word), .word_valid_i(wvalid),
        .word_ready_o(wready), .must_lead_left_i(mll), .must_lead_right_i(mlr),
        .branch_taken_i(br), .exec_cond_i(cond), .issue_valid_o(ivalid),
        .issue_tag_o(itag), .issue_payload_o(ipay), .cnt_long_o(c_long),
        .cnt_left_o(c_left), .cnt_right_o(c_right), .cnt_lpar_o(c_lpar),
        .cnt_rpar_o(c_rpar)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [33:0] beat(input int tag, input logic [29:0] p);
        return {1'b1, tag[2:0], p};
    endfunction

    function automatic logic [33:0] exp_first(input logic [31:0] w, input logic l, input logic r);
        logic [29:0] lf = {15'b0, w[29:15]};
        logic [29:0] rt = {15'b0, w[14:0]};
        case (w[31:30])
            2'b11:   return beat(0, w[29:0]);
            2'b01:   return beat(1, lf);
            2'b10:   return beat(2, rt);
            default: return l ? beat(1, lf) : (r ? beat(2, rt) : beat(3, lf));
        endcase
    endfunction

    function automatic logic [33:0] exp_second(input logic [31:0] w, input logic l, input logic r,
                                                input logic b, input logic c);
        logic [29:0] lf = {15'b0, w[29:15]};
        logic [29:0] rt = {15'b0, w[14:0]};
        case (w[31:30])
            2'b11:   return '0;
            2'b01:   return b ? '0 : beat(2, rt);
            2'b10:   return b ? '0 : beat(1, lf);
            default: begin
                if (l)      return c ? beat(2, rt) : '0;
                else if (r) return c ? beat(1, lf) : '0;
                else        return beat(4, rt);
            end
        endcase
    endfunction

    function automatic string req_of(input logic [31:0] w, input logic l, input logic r, input logic b);
        case (w[31:30])
            2'b11:   return "R1";
            2'b01:   return b ? "R4" : "R2";
            2'b10:   return b ? "R4" : "R3";
            default: return l ? "R6" : (r ? "R7" : "R5");
        endcase
    endfunction

    task automatic check_beat(input string req, input logic [33:0] exp);
        if (exp[33]) chk(req, {30'b0, ivalid, itag, ipay}, {30'b0, exp});
        else         chk(req, {63'b0, ivalid}, 64'b0);
    endtask

    task automatic note_beat(input logic [33:0] e);
        if (e[33]) model_cnt[e[32:30]]++;
    endtask

    task automatic check_counters(input string req);
        chk({req, " long"},  {48'b0, c_long},  64'(model_cnt[0] % 65536));
        chk({req, " left"},  {48'b0, c_left},  64'(model_cnt[1] % 65536));
        chk({req, " right"}, {48'b0, c_right}, 64'(model_cnt[2] % 65536));
        chk({req, " lpar"},  {48'b0, c_lpar},  64'(model_cnt[3] % 65536));
        chk({req, " rpar"},  {48'b0, c_rpar},  64'(model_cnt[4] % 65536));
    endtask

    task automatic run_word(input logic [31:0] w, input logic l, input logic r,
                            input logic b, input logic c, input string note);
        logic [33:0] e1 = exp_first(w, l, r);
        logic [33:0] e2 = exp_second(w, l, r, b, c);
        string rq = {req_of(w, l, r, b), note};
        @(negedge clk);
        while (!wready) @(negedge clk);
        word = w; mll = l; mlr = r; wvalid = 1'b1;
        br = $urandom_range(0, 1); cond = $urandom_range(0, 1);
        @(negedge clk);
        wvalid = 1'b0; word = $urandom; mll = $urandom_range(0, 1); mlr = $urandom_range(0, 1);
        check_beat({rq, " first"}, e1);
        chk("R9 ready after accept", {63'b0, wready}, {63'b0, w[31:30] == 2'b11});
        br = b; cond = c;
        note_beat(e1);
        @(negedge clk);
        check_beat({rq, " second"}, e2);
        chk("R9 ready after pair", {63'b0, wready}, 64'd1);
        note_beat(e2);
        br = $urandom_range(0, 1); cond = $urandom_range(0, 1);
        @(negedge clk);
        check_counters("R10");
    endtask

    task automatic main_seq();
        rst = 1'b1; wvalid = 1'b0; word = '0; mll = 0; mlr = 0; br = 0; cond = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 reset valid", {63'b0, ivalid}, 64'd0);
        chk("R11 reset ready", {63'b0, wready}, 64'd1);
        check_counters("R11");

        run_word(32'hC000_0000 | 30'h2ABC_DEF1, 1, 1, 1, 0, " R8 flags on long");
        run_word(32'hFFFF_FFFF, 0, 0, 0, 0, " all ones");
        run_word(32'h4000_0000 | (32'h7FFF << 15) | 32'h0123, 0, 0, 0, 0, "");
        run_word(32'h4000_0000 | (32'h1111 << 15) | 32'h7FFF, 0, 0, 1, 0, "");
        run_word(32'h8000_0000 | (32'h0042 << 15) | 32'h7FFF, 0, 0, 0, 0, "");
        run_word(32'h8000_0000 | (32'h7FFF << 15) | 32'h0005, 0, 0, 1, 1, "");
        run_word(32'h4000_0000 | (32'h0A0A << 15) | 32'h0505, 1, 1, 0, 0, " R8 flags on ordered");
        run_word((32'h7FFF << 15) | 32'h0000, 0, 0, 1, 0, " R8 branch on parallel");
        run_word((32'h0001 << 15) | 32'h7FFE, 1, 0, 0, 1, "");
        run_word((32'h0002 << 15) | 32'h7FFD, 1, 0, 0, 0, "");
        run_word((32'h0003 << 15) | 32'h6000, 1, 1, 0, 1, " left priority");
        run_word((32'h0004 << 15) | 32'h5000, 1, 1, 0, 0, " left priority");
        run_word((32'h7000 << 15) | 32'h0006, 0, 1, 0, 1, "");
        run_word((32'h7001 << 15) | 32'h0007, 0, 1, 1, 0, "");

        for (int i = 0; i < 400; i++) begin
            run_word($urandom, $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 1), $urandom_range(0, 1), " random");
        end

        @(negedge clk);
        word = 32'h4000_1234; wvalid = 1'b1;
        @(negedge clk);
        wvalid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) model_cnt[k] = 0;
        chk("R11 mid-pair valid", {63'b0, ivalid}, 64'd0);
        chk("R11 mid-pair ready", {63'b0, wready}, 64'd1);
        check_counters("R11");
        @(negedge clk);
        chk("R11 no late beat", {63'b0, ivalid}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 5; k++) model_cnt[k] = 0;
        fork
            main_seq();
            begin
                repeat (60000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule